// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block is the configuration front end of a chip. A host reaches it through two adjacent byte-wide I/O addresses. The lower address carries register indexes and lock keys, and the upper address carries register data. While the port is locked, data accesses have no effect. Writing the opening key byte twice in a row on the index address unlocks it, and a closing key byte locks it again.

Once the port is open, the host writes an index and then reads or writes the addressed register through the data address. Low indexes reach a small set of global registers: a logical-device selector and read-only identification bytes. Indexes from 0x30 up are passed to the currently selected logical device over a single-cycle register bus. The selected device number travels with each access on that bus. A strap input chooses which of two base addresses the block answers at.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the port is locked, the selected device number is 0x00, `io_rvalid`, `dev_wr` and `dev_rd` are low, and `io_rdata` is 0xFF.
- R2: Two consecutive index-address writes of 0x87 unlock the port. Once open, a data read returns the register selected by the last index written.
- R3: An index-address write of 0xAA while open locks the port, and is not stored as an index.
- R4: A single 0x87 followed by any other index-address byte clears the key progress, so 0x87, 0x55, 0x87 leaves the port locked.
- R5: While locked, data writes change no register and raise no `dev_wr`. Data reads return 0xFF. Index writes other than the keys leave the stored index unchanged.
- R6: Global index 0x07 is a read/write register that holds the selected device number, which is driven on `dev_ldn`.
- R7: Global indexes 0x20 and 0x21 read the device ID high and low bytes (default 0x0A51). Index 0x22 reads the revision (default 0x12). Indexes 0x23 and 0x24 read the manufacturer ID high and low bytes (0x1934). All five are read-only.
- R8: While open, a data write to an index of 0x30 or above raises `dev_wr` in the same cycle, with `dev_idx`, `dev_wdata` and `dev_ldn` valid. A data read to such an index raises `dev_rd` and returns `dev_rdata`.
- R9: With `base_sel` low the port answers at 0x2E (index) and 0x2F (data). With it high the port answers at 0x4E and 0x4F. Accesses to any other address produce no response.
- R10: Every read that hits either port address produces one `io_rvalid` pulse in the following cycle, with `io_rdata` valid in that cycle.
- R11: Global indexes below 0x30 other than 0x07 and 0x20 to 0x24 read as 0x00, and writes to them are dropped.
- R12: A read of the index address returns the stored index while open and 0xFF while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_sel | input | 1 | Base address select: 0 for 0x2E, 1 for 0x4E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe, one cycle per byte |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data, valid while io_rvalid is high |
| io_rvalid | output | 1 | Read response pulse |
| dev_wr | output | 1 | Write strobe to the selected logical device |
| dev_rd | output | 1 | Read strobe to the selected logical device |
| dev_ldn | output | 8 | Selected logical device number |
| dev_idx | output | 8 | Register index forwarded to the device |
| dev_wdata | output | 8 | Write data forwarded to the device |
| dev_rdata | input | 8 | Device read data, sampled in the `dev_rd` cycle |

## Verification
The assertions assume that the host never raises `io_wr` and `io_rd` in the same cycle. They also assume that `dev_rdata` is valid combinationally in any cycle in which `dev_rd` is high. The bench drives each host access as a single one-cycle strobe of one kind, with idle cycles between accesses. Its device model returns a byte computed combinationally from `dev_ldn` and `dev_idx`, so a forwarded read is answered within the same cycle.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [1:0] {
    LK_CLOSED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_st_t;

  localparam logic [7:0] KEY_OPEN     = 8'h87;
  localparam logic [7:0] KEY_CLOSE    = 8'hAA;
  localparam logic [7:0] IDX_LDSEL    = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO = 8'h21;
  localparam logic [7:0] IDX_REV      = 8'h22;
  localparam logic [7:0] IDX_MFR_HI   = 8'h23;
  localparam logic [7:0] IDX_MFR_LO   = 8'h24;
  localparam logic [7:0] IDX_DEV_BASE = 8'h30;
  localparam logic [7:0] IDLE_BYTE    = 8'hFF;

  // Key tracker step for one byte written to the index address.
  function automatic lock_st_t lock_next(lock_st_t cur, logic [7:0] b);
    lock_st_t nxt;
    case (cur)
      LK_CLOSED: nxt = (b == KEY_OPEN)  ? LK_ARMED  : LK_CLOSED;
      LK_ARMED:  nxt = (b == KEY_OPEN)  ? LK_OPEN   : LK_CLOSED;
      LK_OPEN:   nxt = (b == KEY_CLOSE) ? LK_CLOSED : LK_OPEN;
      default:   nxt = LK_CLOSED;
    endcase
    return nxt;
  endfunction

  function automatic logic routes_to_device(logic [7:0] idx);
    return idx >= IDX_DEV_BASE;
  endfunction

  // Read-only identification bytes; unknown global indexes read zero.
  function automatic logic [7:0] id_byte(logic [7:0] idx, logic [15:0] dev_id,
                                         logic [7:0] rev, logic [15:0] mfr_id);
    logic [7:0] r;
    case (idx)
      IDX_DEVID_HI: r = dev_id[15:8];
      IDX_DEVID_LO: r = dev_id[7:0];
      IDX_REV:      r = rev;
      IDX_MFR_HI:   r = mfr_id[15:8];
      IDX_MFR_LO:   r = mfr_id[7:0];
      default:      r = 8'h00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_A = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_B = 16'h004E
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              base_sel,
  input  logic              wr,
  input  logic              rd,
  output logic              idx_wr,
  output logic              data_wr,
  output logic              idx_rd,
  output logic              data_rd
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] base;
  logic              hit_idx;
  logic              hit_data;

  always_comb begin
    base     = base_sel ? BASE_B : BASE_A;
    hit_idx  = (addr == base);
    hit_data = (addr == base + ONE);
    idx_wr   = wr & hit_idx;
    data_wr  = wr & hit_data;
    idx_rd   = rd & hit_idx;
    data_rd  = rd & hit_data;
  end
endmodule

// File: rtl/cfg_key_tracker.sv
module cfg_key_tracker
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open
);
  lock_st_t st;

  always_ff @(posedge clk) begin
    if (!rst_n)      st <= LK_CLOSED;
    else if (idx_wr) st <= lock_next(st, wdata);
  end

  assign open = (st == LK_OPEN);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0A51,
  parameter logic [7:0]  DEV_REV = 8'h12,
  parameter logic [15:0] MFR_ID  = 16'h1934
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] rd_byte
);
  logic ldn_wr;
  assign ldn_wr = wr_en & (idx == IDX_LDSEL);

  always_ff @(posedge clk) begin
    if (!rst_n)      ldn <= 8'h00;
    else if (ldn_wr) ldn <= wdata;
  end

  always_comb begin
    if (idx == IDX_LDSEL) rd_byte = ldn;
    else                  rd_byte = id_byte(idx, DEV_ID, DEV_REV, MFR_ID);
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE_A  = 16'h002E,
  parameter logic [ADDR_W-1:0] BASE_B  = 16'h004E,
  parameter logic [15:0]     DEV_ID  = 16'h0A51,
  parameter logic [7:0]      DEV_REV = 8'h12,
  parameter logic [15:0]     MFR_ID  = 16'h1934
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_sel,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [7:0]        dev_ldn,
  output logic [7:0]        dev_idx,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);
  // Named internal events, also used by the bound checker.
  logic       idx_port_wr;
  logic       data_port_wr;
  logic       idx_port_rd;
  logic       data_port_rd;
  logic       any_port_rd;
  logic       cfg_open;
  logic       idx_store;
  logic       to_device;
  logic       glob_wr;
  logic [7:0] cur_idx;
  logic [7:0] glob_byte;
  logic [7:0] ldn;
  logic [7:0] rd_next;

  cfg_port_decode #(.ADDR_W(ADDR_W), .BASE_A(BASE_A), .BASE_B(BASE_B)) u_dec (
    .addr    (io_addr),
    .base_sel(base_sel),
    .wr      (io_wr),
    .rd      (io_rd),
    .idx_wr  (idx_port_wr),
    .data_wr (data_port_wr),
    .idx_rd  (idx_port_rd),
    .data_rd (data_port_rd)
  );

  cfg_key_tracker u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .idx_wr(idx_port_wr),
    .wdata (io_wdata),
    .open  (cfg_open)
  );

  assign any_port_rd = idx_port_rd | data_port_rd;
  assign idx_store   = idx_port_wr & cfg_open & (io_wdata != KEY_CLOSE);
  assign to_device   = routes_to_device(cur_idx);
  assign glob_wr     = data_port_wr & cfg_open & ~to_device;

  always_ff @(posedge clk) begin
    if (!rst_n)         cur_idx <= 8'h00;
    else if (idx_store) cur_idx <= io_wdata;
  end

  cfg_global_regs #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .MFR_ID(MFR_ID)) u_glob (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (glob_wr),
    .idx    (cur_idx),
    .wdata  (io_wdata),
    .ldn    (ldn),
    .rd_byte(glob_byte)
  );

  assign dev_wr    = data_port_wr & cfg_open & to_device;
  assign dev_rd    = data_port_rd & cfg_open & to_device;
  assign dev_ldn   = ldn;
  assign dev_idx   = cur_idx;
  assign dev_wdata = io_wdata;

  always_comb begin
    if (!cfg_open)        rd_next = IDLE_BYTE;
    else if (idx_port_rd) rd_next = cur_idx;
    else if (to_device)   rd_next = dev_rdata;
    else                  rd_next = glob_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= IDLE_BYTE;
    end else begin
      io_rvalid <= any_port_rd;
      if (any_port_rd) io_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] io_wdata,
  input logic [7:0] io_rdata,
  input logic       io_rvalid,
  input logic       dev_wr,
  input logic       dev_rd,
  input logic [7:0] dev_ldn,
  input logic [7:0] dev_idx,
  input logic       cfg_open,
  input logic       idx_port_wr,
  input logic       data_port_wr,
  input logic       any_port_rd
);
  a_r8_dev_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> cfg_open);

  a_r8_dev_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> (dev_idx >= 8'h30));

  a_r2_open_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(idx_port_wr && io_wdata == 8'h87));

  a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_port_wr && io_wdata == 8'hAA) |=> !cfg_open);

  a_r10_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    any_port_rd |=> io_rvalid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !any_port_rd |=> !io_rvalid);

  a_r5_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (any_port_rd && !cfg_open) |=> (io_rdata == 8'hFF));

  a_r6_ldn_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_port_wr && cfg_open) |=> $stable(dev_ldn));
endmodule

bind cfg_index_port cfg_index_port_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .io_rvalid   (io_rvalid),
  .dev_wr      (dev_wr),
  .dev_rd      (dev_rd),
  .dev_ldn     (dev_ldn),
  .dev_idx     (dev_idx),
  .cfg_open    (cfg_open),
  .idx_port_wr (idx_port_wr),
  .data_port_wr(data_port_wr),
  .any_port_rd (any_port_rd)
);

// File: tb/tb_cfg_index_port.sv
module tb_cfg_index_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_sel = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        dev_wr, dev_rd;
  logic [7:0]  dev_ldn, dev_idx, dev_wdata, dev_rdata;

  int          n_checks = 0;
  int          n_errors = 0;
  logic [15:0] base = 16'h002E;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  // Device model: byte derived from device number and index.
  function automatic logic [7:0] dev_model(logic [7:0] l, logic [7:0] i);
    return {l[3:0], i[3:0]} ^ 8'h5A;
  endfunction
  assign dev_rdata = dev_model(dev_ldn, dev_idx);

  cfg_index_port dut (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_ldn(dev_ldn),
    .dev_idx(dev_idx), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected byte per read response.
  always @(negedge clk) begin
    if (rst_n && io_rvalid) begin
      if (exp_q.size() == 0) chk("R10 unexpected response", 8'h01, 8'h00);
      else chk(tag_q.pop_front(), io_rdata, exp_q.pop_front());
    end
  end

  task automatic wr_port(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_port(logic [15:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic rd_absent(logic [15:0] a, string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    chk(tag, {7'd0, io_rvalid}, 8'h00);
  endtask

  task automatic unlock(); wr_port(base, 8'h87); wr_port(base, 8'h87); endtask
  task automatic relock(); wr_port(base, 8'hAA); endtask
  task automatic set_reg(logic [7:0] i, logic [7:0] d);
    wr_port(base, i); wr_port(base + 16'd1, d);
  endtask
  task automatic exp_reg(logic [7:0] i, logic [7:0] e, string tag);
    wr_port(base, i); rd_port(base + 16'd1, e, tag);
  endtask

  // Data write with same-cycle checks of the device strobe.
  task automatic data_wr_chk(logic [7:0] d, logic exp_wr, logic [7:0] ldn, logic [7:0] i, string tag);
    @(negedge clk);
    io_addr = base + 16'd1; io_wdata = d; io_wr = 1'b1;
    #1;
    chk(tag, {7'd0, dev_wr}, {7'd0, exp_wr});
    if (exp_wr) begin
      chk({tag, " ldn"}, dev_ldn, ldn);
      chk({tag, " idx"}, dev_idx, i);
      chk({tag, " wdata"}, dev_wdata, d);
    end
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rvalid", {7'd0, io_rvalid}, 8'h00);
    chk("R1 rdata", io_rdata, 8'hFF);
    chk("R1 ldn", dev_ldn, 8'h00);
    chk("R1 strobes", {6'd0, dev_wr, dev_rd}, 8'h00);
    // R5 locked reads and R12 locked index read
    rd_port(base + 16'd1, 8'hFF, "R5 locked data read");
    rd_port(base, 8'hFF, "R12 locked index read");
    // R2 unlock, R7 identification
    unlock();
    exp_reg(8'h23, 8'h19, "R7 mfr hi");
    exp_reg(8'h24, 8'h34, "R7 mfr lo");
    exp_reg(8'h20, 8'h0A, "R7 devid hi");
    exp_reg(8'h21, 8'h51, "R7 devid lo");
    exp_reg(8'h22, 8'h12, "R7 rev");
    set_reg(8'h22, 8'h77);
    exp_reg(8'h22, 8'h12, "R7 rev read-only");
    // R11 undefined globals
    exp_reg(8'h10, 8'h00, "R11 undefined read");
    set_reg(8'h10, 8'h66);
    exp_reg(8'h10, 8'h00, "R11 undefined write dropped");
    // R6 device select
    set_reg(8'h07, 8'h06);
    exp_reg(8'h07, 8'h06, "R6 ldn readback");
    chk("R6 dev_ldn", dev_ldn, 8'h06);
    // R8 forwarding
    wr_port(base, 8'h41);
    data_wr_chk(8'h3C, 1'b1, 8'h06, 8'h41, "R8 dev write");
    rd_port(base + 16'd1, dev_model(8'h06, 8'h41), "R8 dev read");
    wr_port(base, 8'h30);
    rd_port(base + 16'd1, dev_model(8'h06, 8'h30), "R8 boundary 0x30");
    wr_port(base, 8'h2F);
    data_wr_chk(8'h11, 1'b0, 8'h06, 8'h2F, "R8 no strobe at 0x2F");
    // R12 index readback while open
    wr_port(base, 8'h41);
    rd_port(base, 8'h41, "R12 open index read");
    // R3 relock, closing key not stored
    relock();
    rd_port(base + 16'd1, 8'hFF, "R3 locked after close key");
    // R5 ignored stimulus while locked
    data_wr_chk(8'h99, 1'b0, 8'h06, 8'h41, "R5 locked data write");
    wr_port(base, 8'h20);
    unlock();
    rd_port(base, 8'h41, "R5 index kept and R3 close key not stored");
    wr_port(base, 8'h07);
    relock();
    wr_port(base + 16'd1, 8'h99);
    unlock();
    rd_port(base + 16'd1, 8'h06, "R5 ldn unchanged by locked write");
    relock();
    // R4 broken key sequence
    wr_port(base, 8'h87);
    wr_port(base, 8'h55);
    wr_port(base, 8'h87);
    rd_port(base + 16'd1, 8'hFF, "R4 tracker reset");
    relock();
    // R9 alternate base
    base_sel = 1'b1;
    rd_absent(16'h002F, "R9 old base silent");
    rd_absent(16'h0030, "R9 foreign address silent");
    base = 16'h004E;
    unlock();
    exp_reg(8'h23, 8'h19, "R9 alternate base mfr");
    exp_reg(8'h07, 8'h06, "R9 alternate base ldn");
    relock();
    repeat (4) @(negedge clk);
    chk("R10 all responses seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule